// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block is the management-register side of a 10/100 Ethernet PHY, as seen by a MAC-side controller. The controller issues parallel access strobes carrying a 5-bit PHY address, a 5-bit register index and, for writes, a 16-bit data word. The block holds the control and advertisement registers, derives the status and link-partner words from a live link input, and returns two fixed identifier words. The serial management pin framing is outside this block; each access arrives as a one-cycle strobe.

Three finite state machines make up the design. The link tracker has states LNK_DOWN and LNK_UP. It moves LNK_DOWN to LNK_UP when `link_up` is sampled high, and LNK_UP to LNK_DOWN when it is sampled low. Entering LNK_UP adds the partner abilities to the partner word. Entering LNK_DOWN reduces the partner word to 100TX only. The access responder has states ACC_IDLE and ACC_RESP. A read strobe moves it from either state into ACC_RESP, and it returns to ACC_IDLE when no read strobe is present. The response is presented while it is in ACC_RESP. Writing the control register with bit 15 set performs a soft reset. This restores control and advertisement to their initial values and reloads the link tracker and partner word from the current link level.

Register indices are 0 control, 1 status, 2 identifier high, 3 identifier low, 4 advertisement and 5 link partner. Index 6 is expansion. Indices 7 to 31 include the vendor range and undefined slots.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, with `link_up` low, the registers read as follows: control 0x3100 (bit 13 speed 100, bit 12 autonegotiation enable, bit 8 full duplex), status 0x7848 (bits 14..11 ability, bit 6 preamble suppression, bit 3 autonegotiation ability), advertisement 0x01E1 (bits 8,7,6,5 and selector 0x01), partner 0x0080.
- R2: Once the link tracker has sampled `link_up` high, status reads 0x786C, which adds bit 2 link status and bit 5 autonegotiation complete. The partner word then gains bits 8, 6, 5 and 0, reading 0x01E1.
- R3: Once the link tracker has sampled `link_up` low after being up, status bits 2 and 5 clear (0x7848) and the partner word reads 0x0080.
- R4: A write to index 0 with bit 15 clear stores the data as written. A write to index 4 stores the data as written.
- R5: A write to index 0 with bit 15 set restores control to 0x3100 and advertisement to 0x01E1. Status and partner then reflect the current `link_up` level.
- R6: A read addressed to a PHY address other than `PHY_ADDR` returns 0xFFFF. A write addressed to one changes no register.
- R7: Writes to indices 1, 2, 3, 5, 6 and 7..31 change no register.
- R8: Reads of index 2 return `ID_HI`, and reads of index 3 return `ID_LO`.
- R9: Reads of index 6 and of indices 7..31 return 0x0000.
- R10: `mgmt_rvalid` is high in exactly the cycle after each cycle in which `mgmt_rd` was sampled high, and `mgmt_rdata` holds the read value in that cycle. `mgmt_rvalid` is low otherwise, including after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Live link level, synchronous to clk |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_phy | input | 5 | Target PHY address |
| mgmt_idx | input | 5 | Register index |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data, valid with mgmt_rvalid |
| mgmt_rvalid | output | 1 | Read response valid |

## Verification
The bench goes after a soft reset issued while the link is up. A design that reloaded the link-down state there would report 0x7848 and partner 0x0080 instead of 0x786C and 0x01E1. It checks that writes to status, identifier and partner indices leave those words intact, which catches a write decoder that accepts any index. It checks that a foreign PHY address reads 0xFFFF and that a write to it leaves control untouched, which catches a missing address compare. It also toggles the link down and up again, so a partner word that never cleared, or never regained its bits, shows up as a wrong value.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam int PHY_W  = 5;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // register indices (standard management layout)
    localparam idx_t IDX_CTRL    = idx_t'(0);
    localparam idx_t IDX_STAT    = idx_t'(1);
    localparam idx_t IDX_ID_HI   = idx_t'(2);
    localparam idx_t IDX_ID_LO   = idx_t'(3);
    localparam idx_t IDX_ADV     = idx_t'(4);
    localparam idx_t IDX_PARTNER = idx_t'(5);

    // control bits
    localparam int CTRL_SOFT_RST = 15;
    localparam int CTRL_SPD100   = 13;
    localparam int CTRL_AN_EN    = 12;
    localparam int CTRL_FDX      = 8;

    // status bits
    localparam int STAT_T100_FDX = 14;
    localparam int STAT_T100_HDX = 13;
    localparam int STAT_T10_FDX  = 12;
    localparam int STAT_T10_HDX  = 11;
    localparam int STAT_PRE_SUP  = 6;
    localparam int STAT_AN_DONE  = 5;
    localparam int STAT_AN_ABLE  = 3;
    localparam int STAT_LINK     = 2;

    // ability bits (advertisement / partner)
    localparam int ABL_T100_FDX = 8;
    localparam int ABL_T100     = 7;
    localparam int ABL_T10_FDX  = 6;
    localparam int ABL_T10      = 5;
    localparam int ABL_SEL_CSMA = 0;

    localparam word_t ONE = word_t'(1);

    localparam word_t CTRL_INIT = (ONE << CTRL_SPD100) | (ONE << CTRL_AN_EN)
                                | (ONE << CTRL_FDX);
    localparam word_t STAT_FIXED = (ONE << STAT_T100_FDX) | (ONE << STAT_T100_HDX)
                                 | (ONE << STAT_T10_FDX)  | (ONE << STAT_T10_HDX)
                                 | (ONE << STAT_PRE_SUP)  | (ONE << STAT_AN_ABLE);
    localparam word_t STAT_LINK_SET = (ONE << STAT_LINK) | (ONE << STAT_AN_DONE);
    localparam word_t ADV_INIT = (ONE << ABL_T100_FDX) | (ONE << ABL_T100)
                               | (ONE << ABL_T10_FDX)  | (ONE << ABL_T10)
                               | (ONE << ABL_SEL_CSMA);
    localparam word_t PARTNER_DOWN = ONE << ABL_T100;
    localparam word_t PARTNER_UP_ADD = (ONE << ABL_T100_FDX) | (ONE << ABL_T10_FDX)
                                     | (ONE << ABL_T10)      | (ONE << ABL_SEL_CSMA);

    typedef enum logic {LNK_DOWN, LNK_UP} link_state_e;
    typedef enum logic {ACC_IDLE, ACC_RESP} acc_state_e;

endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
    import phy_mgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  link_up,
    input  logic  soft_rst,
    output word_t stat_word,
    output word_t partner_q
);

    link_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LNK_DOWN;
        else        state_q <= state_nx;
    end

    // transitions; soft reset reloads from the live level, which the
    // ordinary transitions already do
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LNK_DOWN: if (link_up)  state_nx = LNK_UP;
            LNK_UP:   if (!link_up) state_nx = LNK_DOWN;
        endcase
    end

    // partner word, updated on entry to each state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            partner_q <= PARTNER_DOWN;
        end else if (soft_rst) begin
            partner_q <= link_up ? (PARTNER_DOWN | PARTNER_UP_ADD) : PARTNER_DOWN;
        end else if (state_q == LNK_DOWN && state_nx == LNK_UP) begin
            partner_q <= partner_q | PARTNER_UP_ADD;
        end else if (state_q == LNK_UP && state_nx == LNK_DOWN) begin
            partner_q <= PARTNER_DOWN;
        end
    end

    // outputs
    always_comb begin
        stat_word = STAT_FIXED;
        unique case (state_q)
            LNK_DOWN: stat_word = STAT_FIXED;
            LNK_UP:   stat_word = STAT_FIXED | STAT_LINK_SET;
        endcase
    end

endmodule

// File: rtl/phy_ctrl_bank.sv
module phy_ctrl_bank
    import phy_mgmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_hit,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    output logic  soft_rst,
    output word_t ctrl_q,
    output word_t adv_q
);

    logic ctrl_sel, adv_sel;

    always_comb begin
        ctrl_sel = wr_hit && (wr_idx == IDX_CTRL);
        adv_sel  = wr_hit && (wr_idx == IDX_ADV);
        soft_rst = ctrl_sel && wr_data[CTRL_SOFT_RST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= CTRL_INIT;
            adv_q  <= ADV_INIT;
        end else begin
            if (ctrl_sel) ctrl_q <= wr_data;
            if (adv_sel)  adv_q  <= wr_data;
        end
    end

endmodule

// File: rtl/phy_read_port.sv
module phy_read_port
    import phy_mgmt_pkg::*;
#(
    parameter word_t ID_HI = 16'h0143,
    parameter word_t ID_LO = 16'hBC70
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_req,
    input  logic  rd_hit,
    input  idx_t  rd_idx,
    input  word_t ctrl_q,
    input  word_t stat_word,
    input  word_t adv_q,
    input  word_t partner_q,
    output word_t rd_data,
    output logic  rd_valid
);

    acc_state_e state_q, state_nx;
    word_t      sel_word;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_req)  state_nx = ACC_RESP;
            ACC_RESP: if (!rd_req) state_nx = ACC_IDLE;
        endcase
    end

    // index decode; expansion, vendor and undefined slots read zero
    always_comb begin
        sel_word = '0;
        if (!rd_hit) begin
            sel_word = '1;
        end else begin
            unique case (rd_idx)
                IDX_CTRL:    sel_word = ctrl_q;
                IDX_STAT:    sel_word = stat_word;
                IDX_ID_HI:   sel_word = ID_HI;
                IDX_ID_LO:   sel_word = ID_LO;
                IDX_ADV:     sel_word = adv_q;
                IDX_PARTNER: sel_word = partner_q;
                default:     sel_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= sel_word;
    end

    always_comb rd_valid = (state_q == ACC_RESP);

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1,
    parameter word_t ID_HI = 16'h0143,
    parameter word_t ID_LO = 16'hBC70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              mgmt_rd,
    input  logic              mgmt_wr,
    input  logic [PHY_W-1:0]  mgmt_phy,
    input  logic [IDX_W-1:0]  mgmt_idx,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata,
    output logic              mgmt_rvalid
);

    logic  addr_match, soft_rst;
    word_t ctrl_q, adv_q, stat_word, partner_q;

    always_comb addr_match = (mgmt_phy == PHY_ADDR);

    phy_ctrl_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (mgmt_wr && addr_match),
        .wr_idx   (mgmt_idx),
        .wr_data  (mgmt_wdata),
        .soft_rst (soft_rst),
        .ctrl_q   (ctrl_q),
        .adv_q    (adv_q)
    );

    phy_link_tracker u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .soft_rst  (soft_rst),
        .stat_word (stat_word),
        .partner_q (partner_q)
    );

    phy_read_port #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (mgmt_rd),
        .rd_hit    (addr_match),
        .rd_idx    (mgmt_idx),
        .ctrl_q    (ctrl_q),
        .stat_word (stat_word),
        .adv_q     (adv_q),
        .partner_q (partner_q),
        .rd_data   (mgmt_rdata),
        .rd_valid  (mgmt_rvalid)
    );

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk
    import phy_mgmt_pkg::*;
#(
    parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1,
    parameter word_t ID_HI = 16'h0143,
    parameter word_t ID_LO = 16'hBC70
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mgmt_rd,
    input logic              mgmt_wr,
    input logic [PHY_W-1:0]  mgmt_phy,
    input logic [IDX_W-1:0]  mgmt_idx,
    input logic [DATA_W-1:0] mgmt_wdata,
    input logic [DATA_W-1:0] mgmt_rdata,
    input logic              mgmt_rvalid,
    input word_t             ctrl_q,
    input word_t             adv_q
);

    logic hit;
    always_comb hit = (mgmt_phy == PHY_ADDR);

    p_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && hit && mgmt_idx == IDX_STAT) |=>
        ((mgmt_rdata & ~STAT_LINK_SET) == STAT_FIXED) &&
        (mgmt_rdata[STAT_LINK] == mgmt_rdata[STAT_AN_DONE]));

    p_partner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && hit && mgmt_idx == IDX_PARTNER) |=>
        (mgmt_rdata == PARTNER_DOWN || mgmt_rdata == (PARTNER_DOWN | PARTNER_UP_ADD)));

    p_adv_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && hit && mgmt_idx == IDX_ADV) |=> adv_q == $past(mgmt_wdata));

    p_ctrl_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && hit && mgmt_idx == IDX_CTRL && !mgmt_wdata[CTRL_SOFT_RST]) |=>
        ctrl_q == $past(mgmt_wdata));

    p_soft_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && hit && mgmt_idx == IDX_CTRL && mgmt_wdata[CTRL_SOFT_RST]) |=>
        (ctrl_q == CTRL_INIT && adv_q == ADV_INIT));

    p_foreign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && !hit) |=> mgmt_rdata == '1);

    p_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_wr && !(hit && (mgmt_idx == IDX_CTRL || mgmt_idx == IDX_ADV))) |=>
        ($stable(ctrl_q) && $stable(adv_q)));

    p_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && hit && mgmt_idx == IDX_ID_HI) |=> mgmt_rdata == ID_HI);

    p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_rd && hit && mgmt_idx > IDX_PARTNER) |=> mgmt_rdata == '0);

    p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rd |=> mgmt_rvalid);

    p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_rd |=> !mgmt_rvalid);

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(
    .PHY_ADDR (PHY_ADDR),
    .ID_HI    (ID_HI),
    .ID_LO    (ID_LO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mgmt_rd     (mgmt_rd),
    .mgmt_wr     (mgmt_wr),
    .mgmt_phy    (mgmt_phy),
    .mgmt_idx    (mgmt_idx),
    .mgmt_wdata  (mgmt_wdata),
    .mgmt_rdata  (mgmt_rdata),
    .mgmt_rvalid (mgmt_rvalid),
    .ctrl_q      (ctrl_q),
    .adv_q       (adv_q)
);

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;

    localparam logic [4:0]  ADDR = 5'd3;
    localparam logic [15:0] IDH  = 16'h2A5C;
    localparam logic [15:0] IDL  = 16'h91E3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        mgmt_rd = 1'b0;
    logic        mgmt_wr = 1'b0;
    logic [4:0]  mgmt_phy = '0;
    logic [4:0]  mgmt_idx = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        mgmt_rvalid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phy_mgmt_regs #(.PHY_ADDR(ADDR), .ID_HI(IDH), .ID_LO(IDL)) u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .mgmt_rd(mgmt_rd), .mgmt_wr(mgmt_wr), .mgmt_phy(mgmt_phy),
        .mgmt_idx(mgmt_idx), .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata), .mgmt_rvalid(mgmt_rvalid)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [4:0] phy, input logic [4:0] idx,
                            input logic [15:0] exp);
        @(negedge clk);
        mgmt_rd = 1'b1; mgmt_phy = phy; mgmt_idx = idx;
        @(negedge clk);
        mgmt_rd = 1'b0;
        check({tag, " rvalid (R10)"}, {15'd0, mgmt_rvalid}, 16'd1);
        check(tag, mgmt_rdata, exp);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] d);
        @(negedge clk);
        mgmt_wr = 1'b1; mgmt_phy = phy; mgmt_idx = idx; mgmt_wdata = d;
        @(negedge clk);
        mgmt_wr = 1'b0;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
    endtask

    task automatic t_reset_values;
        check("R1 idle rvalid / R10", {15'd0, mgmt_rvalid}, 16'd0);
        rd_check("R1 control", ADDR, 5'd0, 16'h3100);
        rd_check("R1 status", ADDR, 5'd1, 16'h7848);
        rd_check("R1 advert", ADDR, 5'd4, 16'h01E1);
        rd_check("R1 partner", ADDR, 5'd5, 16'h0080);
    endtask

    task automatic t_ids_and_zero;
        rd_check("R8 id high", ADDR, 5'd2, IDH);
        rd_check("R8 id low", ADDR, 5'd3, IDL);
        rd_check("R9 expansion", ADDR, 5'd6, 16'h0000);
        rd_check("R9 undefined 10", ADDR, 5'd10, 16'h0000);
        rd_check("R9 vendor 16", ADDR, 5'd16, 16'h0000);
        rd_check("R9 vendor 25", ADDR, 5'd25, 16'h0000);
    endtask

    task automatic t_link_up;
        set_link(1'b1);
        rd_check("R2 status up", ADDR, 5'd1, 16'h786C);
        rd_check("R2 partner up", ADDR, 5'd5, 16'h01E1);
    endtask

    task automatic t_writes;
        wr(ADDR, 5'd0, 16'h2100);
        check("R10 no rvalid after write", {15'd0, mgmt_rvalid}, 16'd0);
        rd_check("R4 control write", ADDR, 5'd0, 16'h2100);
        wr(ADDR, 5'd4, 16'h0061);
        rd_check("R4 advert write", ADDR, 5'd4, 16'h0061);
    endtask

    task automatic t_read_only;
        wr(ADDR, 5'd1, 16'h0000);
        wr(ADDR, 5'd2, 16'h0000);
        wr(ADDR, 5'd5, 16'h0000);
        wr(ADDR, 5'd6, 16'hFFFF);
        wr(ADDR, 5'd17, 16'hFFFF);
        rd_check("R7 status kept", ADDR, 5'd1, 16'h786C);
        rd_check("R7 id kept", ADDR, 5'd2, IDH);
        rd_check("R7 partner kept", ADDR, 5'd5, 16'h01E1);
        rd_check("R7 control kept", ADDR, 5'd0, 16'h2100);
        rd_check("R7 advert kept", ADDR, 5'd4, 16'h0061);
    endtask

    task automatic t_foreign;
        rd_check("R6 foreign read", ADDR + 5'd1, 5'd0, 16'hFFFF);
        rd_check("R6 foreign read id", 5'd0, 5'd2, 16'hFFFF);
        wr(ADDR + 5'd1, 5'd0, 16'h0000);
        wr(5'd0, 5'd4, 16'h0000);
        rd_check("R6 foreign write ignored ctrl", ADDR, 5'd0, 16'h2100);
        rd_check("R6 foreign write ignored adv", ADDR, 5'd4, 16'h0061);
    endtask

    task automatic t_soft_reset_up;
        wr(ADDR, 5'd0, 16'h8000);
        rd_check("R5 control restored", ADDR, 5'd0, 16'h3100);
        rd_check("R5 advert restored", ADDR, 5'd4, 16'h01E1);
        rd_check("R5 status keeps link", ADDR, 5'd1, 16'h786C);
        rd_check("R5 partner keeps link", ADDR, 5'd5, 16'h01E1);
    endtask

    task automatic t_link_cycle;
        set_link(1'b0);
        rd_check("R3 status down", ADDR, 5'd1, 16'h7848);
        rd_check("R3 partner down", ADDR, 5'd5, 16'h0080);
        set_link(1'b1);
        rd_check("R2 partner back up", ADDR, 5'd5, 16'h01E1);
        set_link(1'b0);
        wr(ADDR, 5'd4, 16'h0021);
        wr(ADDR, 5'd0, 16'h9234);
        rd_check("R5 soft reset down control", ADDR, 5'd0, 16'h3100);
        rd_check("R5 soft reset down advert", ADDR, 5'd4, 16'h01E1);
        rd_check("R5 soft reset down partner", ADDR, 5'd5, 16'h0080);
        rd_check("R3 soft reset down status", ADDR, 5'd1, 16'h7848);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_ids_and_zero();
        t_link_up();
        t_writes();
        t_read_only();
        t_foreign();
        t_soft_reset_up();
        t_link_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule